// File: doc/BRIEF.md
# DRAM Mode-Register Init Sequencer

This block takes an attached SDRAM device from power-up to a configured state. Once a start pulse arrives, it raises a power-up request and waits for the power-up-done status. It then walks a fixed list of initialisation commands chosen by the memory type: DDR3, LPDDR2 or LPDDR3. The memory type and the programmed mode-register values are captured when the start pulse is accepted, and the rest of the run uses those captured copies.

Commands leave the block through a single command-word port. The top bit of the word is a start flag. The flag stays set, with the word unchanged, until the executing logic returns an acknowledge. Only then does the flag clear, and only after that can the next command go out. Some steps are followed by a pause, counted in core clock cycles through a cycles-per-microsecond parameter. When the last command has been acknowledged, a one-cycle done pulse marks the end of the sequence.

Top module: `mrinit_seq`

## Requirements
- R1: After reset, busy_o, done_o, pwr_up_req_o and cmd_valid_o are all low and cmd_word_o is zero.
- R2: A start_i pulse while idle sets busy_o and pwr_up_req_o. No command is posted until pwr_up_done_i is seen high. The request drops when the status is seen.
- R3: The command word layout is as follows. Bit 31 is the start flag and is equal to cmd_valid_o. Bits 21:20 are the rank mask and are always 2'b11, which selects both ranks. Bits 19:4 hold the argument and bits 3:0 the command code. Bits 30:22 are zero. The codes are: deselect 1, mode-register set 3, precharge-all 5, long ZQ calibration 6.
- R4: A posted word keeps its flag set and stays unchanged until cmd_ack_i is sampled high. The flag is low in the next cycle, and it stays low for at least one cycle before the next command is posted.
- R5: For memory type 0 (DDR3), seven commands go out in this order: deselect, precharge-all, four mode-register sets, then ZQ calibration. In each mode-register set the argument is {bank[2:0], addr[12:0]}. The bank values are 2, 3, 1 and 0 in that order, carrying MR2, MR3, MR1, and MR0 with bit 8 (DLL reset) forced to 1.
- R6: For memory type 1 (LPDDR2), six mode-register writes go out with argument {address[7:0], operand[7:0]}, in this order: 0x3F/0x00, 0x10/0xFF, 0x10/0xFF, then 1, 2 and 3 carrying the low 8 bits of MR1, MR2 and MR3.
- R7: For memory type 2 (LPDDR3), the LPDDR2 list is followed by a seventh write to address 11 with operand mr11_i.
- R8: After each acknowledge, the flag stays low for 1 + W*CYC_PER_US cycles. W is 1 after the DDR3 deselect, 10 after the LPDDR reset write (address 0x3F), 1 after each LPDDR write to address 0x10, and 0 everywhere else.
- R9: done_o is high for exactly one cycle, the cycle right after the last acknowledge is sampled. busy_o is low from that cycle on.
- R10: A start_i that arrives while busy_o is high is ignored. Changes to mem_type_i and the mr inputs after start is accepted do not change the commands issued.
- R11: Memory type 3 runs the same list as LPDDR2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; honoured only when idle |
| mem_type_i | input | 2 | 0 DDR3, 1 LPDDR2, 2 LPDDR3, 3 treated as LPDDR2 |
| mr0_i | input | 13 | Programmed MR0 value |
| mr1_i | input | 13 | Programmed MR1 value |
| mr2_i | input | 13 | Programmed MR2 value |
| mr3_i | input | 13 | Programmed MR3 value |
| mr11_i | input | 8 | Programmed MR11 value (LPDDR3 only) |
| pwr_up_req_o | output | 1 | Power-up request, held until done status is seen |
| pwr_up_done_i | input | 1 | Power-up done status |
| cmd_word_o | output | 32 | Command word with start flag in bit 31 |
| cmd_valid_o | output | 1 | Start flag (copy of bit 31) |
| cmd_ack_i | input | 1 | Command executed; clears the flag |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench runs all four type encodings and checks every posted word and every low-flag gap. If the DLL-reset OR were dropped, the DDR3 MR0 argument would be wrong. If the bank numbers were swapped, the MR order would be wrong. A miscounted pause would show up as a wrong gap length. A missing or unconditional MR11 write would show up as a wrong command count. In the middle of one run, the bench injects a second start together with a changed type and MR0. A design that restarts, or that reads its inputs live instead of from the captured copies, would post a different list. The bench also holds back the acknowledge for several cycles, to catch a flag that clears early. Finally, it resets the block during a run, to check that it returns cleanly to idle.

// File: rtl/mrinit_pkg.sv
package mrinit_pkg;
  localparam int MR_W   = 13;
  localparam int OP_W   = 8;
  localparam int ARG_W  = 16;
  localparam int CODE_W = 4;
  localparam int IDX_W  = 3;
  localparam int US_W   = 4;

  typedef enum logic [1:0] {
    MEM_DDR3   = 2'd0,
    MEM_LPDDR2 = 2'd1,
    MEM_LPDDR3 = 2'd2,
    MEM_ALT    = 2'd3
  } mem_kind_e;

  localparam logic [CODE_W-1:0] OP_DESEL = 4'h1;
  localparam logic [CODE_W-1:0] OP_MRS   = 4'h3;
  localparam logic [CODE_W-1:0] OP_PREA  = 4'h5;
  localparam logic [CODE_W-1:0] OP_ZQL   = 4'h6;
  localparam logic [1:0]        RANK_ALL = 2'b11;
  localparam logic [MR_W-1:0]   DLL_RST  = 13'h0100;
endpackage

// File: rtl/mrinit_step_rom.sv
module mrinit_step_rom
  import mrinit_pkg::*;
(
  input  mem_kind_e                kind_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [MR_W-1:0]          mr0_i,
  input  logic [MR_W-1:0]          mr1_i,
  input  logic [MR_W-1:0]          mr2_i,
  input  logic [MR_W-1:0]          mr3_i,
  input  logic [OP_W-1:0]          mr11_i,
  output logic [CODE_W-1:0]        code_o,
  output logic [ARG_W-1:0]         arg_o,
  output logic [US_W-1:0]          pause_us_o,
  output logic                     last_o
);
  always_comb begin
    code_o     = OP_MRS;
    arg_o      = '0;
    pause_us_o = '0;
    last_o     = 1'b0;
    if (kind_i == MEM_DDR3) begin
      case (idx_i)
        3'd0: begin code_o = OP_DESEL; pause_us_o = 4'd1; end
        3'd1: code_o = OP_PREA;
        3'd2: arg_o = {3'd2, mr2_i};
        3'd3: arg_o = {3'd3, mr3_i};
        3'd4: arg_o = {3'd1, mr1_i};
        3'd5: arg_o = {3'd0, mr0_i | DLL_RST};
        default: begin code_o = OP_ZQL; last_o = 1'b1; end
      endcase
    end else begin
      case (idx_i)
        3'd0: begin arg_o = {8'h3F, 8'h00}; pause_us_o = 4'd10; end
        3'd1, 3'd2: begin arg_o = {8'h10, 8'hFF}; pause_us_o = 4'd1; end
        3'd3: arg_o = {8'd1, mr1_i[OP_W-1:0]};
        3'd4: arg_o = {8'd2, mr2_i[OP_W-1:0]};
        3'd5: begin
          arg_o  = {8'd3, mr3_i[OP_W-1:0]};
          last_o = (kind_i != MEM_LPDDR3);
        end
        default: begin arg_o = {8'd11, mr11_i}; last_o = 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/mrinit_pause.sv
module mrinit_pause
  import mrinit_pkg::*;
#(
  parameter int CYC_PER_US = 50
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [US_W-1:0] us_i,
  output logic            expired_o
);
  localparam int MAX_CYC = ((1 << US_W) - 1) * CYC_PER_US;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= CW'(us_i) * CW'(CYC_PER_US) - CW'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/mrinit_seq.sv
module mrinit_seq
  import mrinit_pkg::*;
#(
  parameter int CYC_PER_US = 50
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic [1:0]  mem_type_i,
  input  logic [12:0] mr0_i,
  input  logic [12:0] mr1_i,
  input  logic [12:0] mr2_i,
  input  logic [12:0] mr3_i,
  input  logic [7:0]  mr11_i,
  output logic        pwr_up_req_o,
  input  logic        pwr_up_done_i,
  output logic [31:0] cmd_word_o,
  output logic        cmd_valid_o,
  input  logic        cmd_ack_i,
  output logic        busy_o,
  output logic        done_o
);
  typedef enum logic [2:0] {S_IDLE, S_PWR, S_POST, S_ACK, S_PAUSE} st_e;

  st_e               st_q;
  mem_kind_e         kind_q;
  logic [MR_W-1:0]   mr0_q, mr1_q, mr2_q, mr3_q;
  logic [OP_W-1:0]   mr11_q;
  logic [IDX_W-1:0]  idx_q;
  logic [30:0]       fields_q;
  logic              valid_q, busy_q, done_q, pwr_q;

  logic [CODE_W-1:0] step_code;
  logic [ARG_W-1:0]  step_arg;
  logic [US_W-1:0]   step_us;
  logic              step_last, pause_load, pause_over;

  mrinit_step_rom u_rom (
    .kind_i(kind_q), .idx_i(idx_q),
    .mr0_i(mr0_q), .mr1_i(mr1_q), .mr2_i(mr2_q), .mr3_i(mr3_q), .mr11_i(mr11_q),
    .code_o(step_code), .arg_o(step_arg), .pause_us_o(step_us), .last_o(step_last)
  );

  assign pause_load = (st_q == S_ACK) && cmd_ack_i && (step_us != '0);

  mrinit_pause #(.CYC_PER_US(CYC_PER_US)) u_pause (
    .clk(clk), .rst(rst), .load_i(pause_load), .us_i(step_us), .expired_o(pause_over)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      kind_q   <= MEM_DDR3;
      mr0_q    <= '0;
      mr1_q    <= '0;
      mr2_q    <= '0;
      mr3_q    <= '0;
      mr11_q   <= '0;
      idx_q    <= '0;
      fields_q <= '0;
      valid_q  <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      pwr_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          kind_q <= mem_kind_e'(mem_type_i);
          mr0_q  <= mr0_i;
          mr1_q  <= mr1_i;
          mr2_q  <= mr2_i;
          mr3_q  <= mr3_i;
          mr11_q <= mr11_i;
          idx_q  <= '0;
          busy_q <= 1'b1;
          pwr_q  <= 1'b1;
          st_q   <= S_PWR;
        end
        S_PWR: if (pwr_up_done_i) begin
          pwr_q <= 1'b0;
          st_q  <= S_POST;
        end
        S_POST: begin
          valid_q  <= 1'b1;
          fields_q <= {9'b0, RANK_ALL, step_arg, step_code};
          st_q     <= S_ACK;
        end
        S_ACK: if (cmd_ack_i) begin
          valid_q <= 1'b0;
          if (step_last) begin
            done_q <= 1'b1;
            busy_q <= 1'b0;
            st_q   <= S_IDLE;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
            st_q  <= (step_us != '0) ? S_PAUSE : S_POST;
          end
        end
        S_PAUSE: if (pause_over) st_q <= S_POST;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_word_o   = {valid_q, fields_q};
  assign cmd_valid_o  = valid_q;
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign pwr_up_req_o = pwr_q;

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o && !cmd_ack_i |=> cmd_valid_o && $stable(cmd_word_o)); // R4
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o && cmd_ack_i |=> !cmd_valid_o); // R4
  AST_RANK_BOTH: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |-> cmd_word_o[21:20] == 2'b11 && cmd_word_o[30:22] == '0); // R3
  AST_NO_CMD_PWRUP: assert property (@(posedge clk) disable iff (rst)
    pwr_up_req_o |-> !cmd_valid_o); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o && !cmd_valid_o); // R9
  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |-> busy_o); // R10
endmodule

// File: tb/test_mrinit_seq.sv
module test_mrinit_seq;
  localparam int CPU = 50;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  mem_type_i = 2'd0;
  logic [12:0] mr0_i = '0, mr1_i = '0, mr2_i = '0, mr3_i = '0;
  logic [7:0]  mr11_i = '0;
  logic        pwr_up_done_i = 1'b0;
  logic        cmd_ack_i = 1'b0;
  logic        pwr_up_req_o, cmd_valid_o, busy_o, done_o;
  logic [31:0] cmd_word_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mrinit_seq #(.CYC_PER_US(CPU)) i_mrinit_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .mem_type_i(mem_type_i),
    .mr0_i(mr0_i), .mr1_i(mr1_i), .mr2_i(mr2_i), .mr3_i(mr3_i), .mr11_i(mr11_i),
    .pwr_up_req_o(pwr_up_req_o), .pwr_up_done_i(pwr_up_done_i),
    .cmd_word_o(cmd_word_o), .cmd_valid_o(cmd_valid_o), .cmd_ack_i(cmd_ack_i),
    .busy_o(busy_o), .done_o(done_o)
  );

  localparam logic [1:0]  T_TYPE [4] = '{2'd0, 2'd1, 2'd2, 2'd3};
  localparam logic [12:0] T_MR0  [4] = '{13'h0520, 13'h0000, 13'h0000, 13'h0000};
  localparam logic [12:0] T_MR1  [4] = '{13'h0044, 13'h01C3, 13'h0083, 13'h0042};
  localparam logic [12:0] T_MR2  [4] = '{13'h0018, 13'h001A, 13'h0106, 13'h0004};
  localparam logic [12:0] T_MR3  [4] = '{13'h0002, 13'h0001, 13'h0002, 13'h0003};
  localparam logic [7:0]  T_MR11 [4] = '{8'h00, 8'h5A, 8'h03, 8'hC1};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [1:0] t);
    return (t == 2'd1 || t == 2'd3) ? 6 : 7;
  endfunction

  function automatic int exp_pause(input logic [1:0] t, input int k);
    if (t == 2'd0) return (k == 0) ? 1 : 0;
    if (k == 0) return 10;
    return (k == 1 || k == 2) ? 1 : 0;
  endfunction

  function automatic logic [31:0] exp_word(input int r, input int k);
    logic [3:0] code;
    logic [15:0] arg;
    logic [1:0] t;
    t = T_TYPE[r];
    code = 4'h3;
    arg = '0;
    if (t == 2'd0) begin
      case (k)
        0: code = 4'h1;
        1: code = 4'h5;
        2: arg = {3'd2, T_MR2[r]};
        3: arg = {3'd3, T_MR3[r]};
        4: arg = {3'd1, T_MR1[r]};
        5: arg = {3'd0, T_MR0[r] | 13'h0100};
        default: code = 4'h6;
      endcase
    end else begin
      case (k)
        0: arg = 16'h3F00;
        1, 2: arg = 16'h10FF;
        3: arg = {8'd1, T_MR1[r][7:0]};
        4: arg = {8'd2, T_MR2[r][7:0]};
        5: arg = {8'd3, T_MR3[r][7:0]};
        default: arg = {8'd11, T_MR11[r]};
      endcase
    end
    return {1'b1, 9'b0, 2'b11, arg, code};
  endfunction

  task automatic run_row(input int r);
    int k, low, held, guard;
    bit inflight, seen_done;
    int inj;
    logic [1:0] t;
    t = T_TYPE[r];
    @(negedge clk);
    mem_type_i = t; mr0_i = T_MR0[r]; mr1_i = T_MR1[r];
    mr2_i = T_MR2[r]; mr3_i = T_MR3[r]; mr11_i = T_MR11[r];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o && pwr_up_req_o, "R2 busy/req after start", {30'b0, busy_o, pwr_up_req_o}, 32'h3);
    repeat (3) begin
      @(negedge clk);
      check(!cmd_valid_o && pwr_up_req_o, "R2 no command before power-up done",
            {30'b0, cmd_valid_o, pwr_up_req_o}, 32'h1);
    end
    pwr_up_done_i = 1'b1;
    k = 0; low = 0; held = 0; guard = 0; inflight = 0; seen_done = 0; inj = 0;
    while (!seen_done && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (inj == 1) begin start_i = 1'b0; inj = 2; end
      if (done_o) begin
        seen_done = 1;
        cmd_ack_i = 1'b0;
        check(k + 1 == exp_len(t), "R5 R6 R7 R11 command count", k + 1, exp_len(t));
        check(!busy_o && !cmd_valid_o, "R9 idle at done", {30'b0, busy_o, cmd_valid_o}, 0);
      end else if (cmd_valid_o) begin
        if (!inflight) begin
          inflight = 1; held = 0;
          check(cmd_word_o == exp_word(r, k), "R3 R5 R6 R7 R11 command word", cmd_word_o, exp_word(r, k));
          if (k > 0)
            check(low == 1 + exp_pause(t, k - 1) * CPU, "R8 flag-low gap", low, 1 + exp_pause(t, k - 1) * CPU);
          if (r == 0 && k == 3 && inj == 0) begin
            start_i = 1'b1; mem_type_i = 2'd2; mr0_i = 13'h1FFF; inj = 1;
          end
        end else begin
          check(cmd_word_o == exp_word(r, k), "R4 word held until ack", cmd_word_o, exp_word(r, k));
        end
        held++;
        cmd_ack_i = (held == 4);
      end else begin
        cmd_ack_i = 1'b0;
        if (inflight) begin inflight = 0; k++; low = 0; end
        low++;
      end
    end
    check(seen_done, "R9 done seen", {31'b0, seen_done}, 1);
    @(negedge clk);
    check(!done_o, "R9 done one cycle", {31'b0, done_o}, 0);
    pwr_up_done_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy_o && !done_o && !pwr_up_req_o && !cmd_valid_o && cmd_word_o == 0,
          "R1 reset state", cmd_word_o, 0);
    for (int r = 0; r < 4; r++) run_row(r);
    // R10: after injected start, row 0 still produced the DDR3 list; now check reset mid-run
    @(negedge clk);
    mem_type_i = 2'd0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; pwr_up_done_i = 1'b1;
    repeat (3) @(negedge clk);
    check(cmd_valid_o, "R2 command after power-up done", {31'b0, cmd_valid_o}, 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; pwr_up_done_i = 1'b0;
    @(negedge clk);
    check(!busy_o && !cmd_valid_o && !pwr_up_req_o && cmd_word_o == 0, "R1 reset mid-run", cmd_word_o, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule